// File: doc/BRIEF.md
# Mirrored Main Memory Address Decoder

This block sits between a processor's 28-bit byte address and a main-memory array. It looks at every address and reports whether it falls on main RAM, and if so which physical byte of the array it reaches. Main RAM is visible through a 16 MB window starting at 0x2000000. It is also visible through two high windows, at 0xC000000 and 0xD000000, which are flagged as uncached. The RAM reachable in all windows wraps with a period equal to the effective size. The effective size is the smaller of the installed capacity and a software-selected size limit, so a small part, or a large part run in a small-limit mode, appears several times across each window.

A 16 KB data TCM window can be placed on any 16 KB boundary of the address space. When it is enabled and the address falls inside it, the block reports a TCM hit, and RAM is hidden at that address even inside a RAM window. The capacity, the size limit and the TCM placement are held in one configuration register. That register is loaded through a single-cycle write port. The decode path is purely combinational.

Top module: `mirror_mem_decoder`

## Requirements
- R1: After synchronous reset the configuration is: size limit 16 MB, installed capacity 4 MB, TCM disabled, TCM base 0.
- R2: An address with bits [27:24] = 0x2 is a RAM hit, and ram_offset = (addr − 0x2000000) masked with (effective size − 1). Such hits are cached (uncached low). ram_offset is zero whenever ram_hit is low.
- R3: The effective size is the minimum of the limit and the capacity. The limit is set by cfg_wdata[1:0]: 0 = 4 MB, 1 = 16 MB, 2 = 32 MB. The capacity is set by cfg_wdata[3:2]: 0 = 4 MB, 1 = 8 MB, 2 = 16 MB, 3 = 32 MB. A 4 MB effective size repeats at 0x2000000, 0x2400000, 0x2800000 and 0x2C00000.
- R4: With the 4 MB limit, the upper 12 MB of the main window mirror the first 4 MB, even when 16 MB or more is installed.
- R5: An 8 MB effective size mirrors once, with 0x2800000 reaching physical offset 0.
- R6: Bits [27:24] = 0xC form a RAM window with the same offset rule as the main window, and uncached is high there.
- R7: Bits [27:24] = 0xD form a RAM window whose raw offset is 0x1000000 + addr[23:0], masked with (effective size − 1), and uncached is high there. With a 32 MB effective size this reaches the upper 16 MB. With 16 MB installed and the 32 MB limit, it mirrors the first 16 MB.
- R8: When TCM is enabled (cfg_wdata[4]) and addr[27:14] equals the base field (cfg_wdata[27:14]), tcm_hit is high and ram_hit is low, even inside a RAM window.
- R9: With TCM disabled, tcm_hit stays low and RAM under the former TCM window is visible.
- R10: Addresses outside the three windows, and not on an enabled TCM window, drive ram_hit, tcm_hit and uncached low.
- R11: A configuration write takes effect on the clock edge where cfg_we is high, and not before. Limit code 3 acts as 32 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: [1:0] limit, [3:2] capacity, [4] TCM enable, [27:14] TCM base |
| addr | input | 28 | Byte address being decoded |
| ram_hit | output | 1 | Address maps onto main RAM |
| ram_offset | output | 25 | Physical byte offset into the RAM array |
| tcm_hit | output | 1 | Address falls in the enabled TCM window |
| uncached | output | 1 | RAM hit came through a high mirror window |

## Verification
The hardest situations are those where two rules interact. One is the TCM overlaying RAM exactly at its 16 KB edges. The other is the 0xD window folding back onto low RAM when the installed capacity is below the limit. Neither is reachable without first reconfiguring the block through its write port. The stimulus therefore pairs every probed address with a configuration word, and probes the bytes just inside and just outside the TCM window. It also probes the 0xD window under several limit and capacity pairs. A directed case checks that the decode still uses the old configuration in the cycle of the write, and switches to the new one after the edge.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
    localparam int ADDR_W   = 28;
    localparam int WIN_LOG2 = 24;
    localparam int OFF_W    = WIN_LOG2 + 1;
    localparam int TCM_LOG2 = 14;
    localparam int BASE_W   = ADDR_W - TCM_LOG2;
    localparam int TOP_W    = ADDR_W - WIN_LOG2;
    localparam int CFG_W    = 32;
    localparam int MIN_LOG2 = 22;

    localparam logic [TOP_W-1:0] MAIN_TOP  = 4'h2;
    localparam logic [TOP_W-1:0] HI_LO_TOP = 4'hC;
    localparam logic [TOP_W-1:0] HI_UP_TOP = 4'hD;

    typedef enum logic [1:0] {LIM_4M, LIM_16M, LIM_32M, LIM_32M_ALT} limit_e;
    typedef enum logic [1:0] {CAP_4M, CAP_8M, CAP_16M, CAP_32M} cap_e;
    typedef enum logic [1:0] {WIN_NONE, WIN_MAIN, WIN_HI_LO, WIN_HI_UP} win_e;

    typedef struct packed {
        limit_e             limit;
        cap_e               cap;
        logic               tcm_en;
        logic [BASE_W-1:0]  tcm_base;
    } cfg_t;

    typedef struct packed {
        win_e               win;
        logic [OFF_W-1:0]   raw_off;
    } dec_t;

    function automatic logic [4:0] limit_log2(limit_e l);
        case (l)
            LIM_4M:  return 5'(MIN_LOG2);
            LIM_16M: return 5'(MIN_LOG2 + 2);
            default: return 5'(MIN_LOG2 + 3);
        endcase
    endfunction

    function automatic logic [4:0] cap_log2(cap_e c);
        return 5'(MIN_LOG2) + 5'(c);
    endfunction

    function automatic logic [4:0] eff_log2(cfg_t c);
        logic [4:0] a, b;
        a = limit_log2(c.limit);
        b = cap_log2(c.cap);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [OFF_W-1:0] size_mask(logic [4:0] lg);
        return (OFF_W'(1) << lg) - OFF_W'(1);
    endfunction
endpackage

// File: rtl/mmd_cfg_reg.sv
module mmd_cfg_reg
    import mmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output cfg_t              cfg
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[CFG_W-1:ADDR_W], wdata[TCM_LOG2-1:5]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.limit    <= LIM_16M;
            cfg.cap      <= CAP_4M;
            cfg.tcm_en   <= 1'b0;
            cfg.tcm_base <= '0;
        end else if (we) begin
            cfg.limit    <= limit_e'(wdata[1:0]);
            cfg.cap      <= cap_e'(wdata[3:2]);
            cfg.tcm_en   <= wdata[4];
            cfg.tcm_base <= wdata[ADDR_W-1:TCM_LOG2];
        end
    end

    assert_reset_cfg_R1: assert property (@(posedge clk)
        $past(rst) |-> (cfg.limit == LIM_16M && cfg.cap == CAP_4M && !cfg.tcm_en));

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg.limit == limit_e'($past(wdata[1:0])) &&
                cfg.tcm_base == $past(wdata[ADDR_W-1:TCM_LOG2])));

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));
endmodule

// File: rtl/mmd_window_dec.sv
module mmd_window_dec
    import mmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [TOP_W-1:0] top;
    assign top = addr[ADDR_W-1:WIN_LOG2];

    always_comb begin
        dec.raw_off = {1'b0, addr[WIN_LOG2-1:0]};
        case (top)
            MAIN_TOP:  dec.win = WIN_MAIN;
            HI_LO_TOP: dec.win = WIN_HI_LO;
            HI_UP_TOP: begin
                dec.win     = WIN_HI_UP;
                dec.raw_off = {1'b1, addr[WIN_LOG2-1:0]};
            end
            default:   dec.win = WIN_NONE;
        endcase
    end
endmodule

// File: rtl/mmd_tcm_match.sv
module mmd_tcm_match
    import mmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    output logic              hit
);
    assign hit = cfg.tcm_en && (addr[ADDR_W-1:TCM_LOG2] == cfg.tcm_base);
endmodule

// File: rtl/mirror_mem_decoder.sv
module mirror_mem_decoder
    import mmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_hit,
    output logic [OFF_W-1:0]  ram_offset,
    output logic              tcm_hit,
    output logic              uncached
);
    cfg_t             cfg;
    dec_t             dec;
    logic [OFF_W-1:0] mask;

    mmd_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    mmd_window_dec u_win (
        .addr (addr),
        .dec  (dec)
    );

    mmd_tcm_match u_tcm (
        .addr (addr),
        .cfg  (cfg),
        .hit  (tcm_hit)
    );

    assign mask       = size_mask(eff_log2(cfg));
    assign ram_hit    = (dec.win != WIN_NONE) && !tcm_hit;
    assign ram_offset = ram_hit ? (dec.raw_off & mask) : '0;
    assign uncached   = ram_hit && (dec.win == WIN_HI_LO || dec.win == WIN_HI_UP);

    assert_tcm_hides_ram_R8: assert property (@(posedge clk) disable iff (rst)
        tcm_hit |-> !ram_hit);

    assert_outside_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:WIN_LOG2] != MAIN_TOP && addr[ADDR_W-1:WIN_LOG2] != HI_LO_TOP &&
         addr[ADDR_W-1:WIN_LOG2] != HI_UP_TOP) |-> (!ram_hit && !uncached));

    assert_offset_in_size_R3: assert property (@(posedge clk) disable iff (rst)
        ram_hit |-> ((ram_offset >> eff_log2(cfg)) == '0));

    assert_main_cached_R2: assert property (@(posedge clk) disable iff (rst)
        (ram_hit && addr[ADDR_W-1:WIN_LOG2] == MAIN_TOP) |-> !uncached);

    assert_high_uncached_R6: assert property (@(posedge clk) disable iff (rst)
        uncached |-> (addr[ADDR_W-1:WIN_LOG2] != MAIN_TOP));

    assert_tcm_off_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg.tcm_en |-> !tcm_hit);
endmodule

// File: tb/test_mirror_mem_decoder.sv
module test_mirror_mem_decoder;
    typedef struct packed {
        logic [31:0] cfg;
        logic [27:0] addr;
        logic        hit;
        logic [24:0] off;
        logic        tcm;
        logic        unc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h1,       28'h2000010, 1'b1, 25'h10,      1'b0, 1'b0, 8'd2},  // R2
        '{32'h1,       28'h2C00010, 1'b1, 25'h10,      1'b0, 1'b0, 8'd3},  // R3 fourth repeat
        '{32'h1,       28'h27FFFFF, 1'b1, 25'h3FFFFF,  1'b0, 1'b0, 8'd2},  // R2
        '{32'h9,       28'h2C00010, 1'b1, 25'hC00010,  1'b0, 1'b0, 8'd3},  // R3
        '{32'h8,       28'h2C00010, 1'b1, 25'h10,      1'b0, 1'b0, 8'd4},  // R4
        '{32'h5,       28'h2800004, 1'b1, 25'h4,       1'b0, 1'b0, 8'd5},  // R5
        '{32'h5,       28'h27FFFFF, 1'b1, 25'h7FFFFF,  1'b0, 1'b0, 8'd5},  // R5
        '{32'hE,       28'hC123456, 1'b1, 25'h123456,  1'b0, 1'b1, 8'd6},  // R6
        '{32'hE,       28'hD123456, 1'b1, 25'h1123456, 1'b0, 1'b1, 8'd7},  // R7
        '{32'hA,       28'hD123456, 1'b1, 25'h123456,  1'b0, 1'b1, 8'd7},  // R7
        '{32'hF,       28'hD000000, 1'b1, 25'h1000000, 1'b0, 1'b1, 8'd11}, // R11
        '{32'hE,       28'h3000000, 1'b0, 25'h0,       1'b0, 1'b0, 8'd10}, // R10
        '{32'hE,       28'h1FFFFFF, 1'b0, 25'h0,       1'b0, 1'b0, 8'd10}, // R10
        '{32'hE,       28'hB000000, 1'b0, 25'h0,       1'b0, 1'b0, 8'd10}, // R10
        '{32'h2FF0019, 28'h2FF0000, 1'b0, 25'h0,       1'b1, 1'b0, 8'd8},  // R8
        '{32'h2FF0019, 28'h2FF3FFF, 1'b0, 25'h0,       1'b1, 1'b0, 8'd8},  // R8
        '{32'h2FF0019, 28'h2FF4000, 1'b1, 25'hFF4000,  1'b0, 1'b0, 8'd8},  // R8
        '{32'h2FF0019, 28'h2FEFFFF, 1'b1, 25'hFEFFFF,  1'b0, 1'b0, 8'd8},  // R8
        '{32'h2FF0009, 28'h2FF0000, 1'b1, 25'hFF0000,  1'b0, 1'b0, 8'd9},  // R9
        '{32'h1000019, 28'h1000100, 1'b0, 25'h0,       1'b1, 1'b0, 8'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [27:0] addr = '0;
    logic        ram_hit, tcm_hit, uncached;
    logic [24:0] ram_offset;
    int          n_checks = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    mirror_mem_decoder i_mirror_mem_decoder (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .addr       (addr),
        .ram_hit    (ram_hit),
        .ram_offset (ram_offset),
        .tcm_hit    (tcm_hit),
        .uncached   (uncached)
    );

    task automatic check(input int req, input logic eh, input logic [24:0] eo,
                         input logic et, input logic eu);
        n_checks++;
        if (ram_hit !== eh || ram_offset !== eo || tcm_hit !== et || uncached !== eu) begin
            n_fail++;
            $display("FAIL R%0d addr=%h: got hit=%b off=%h tcm=%b unc=%b, expected hit=%b off=%h tcm=%b unc=%b",
                     req, addr, ram_hit, ram_offset, tcm_hit, uncached, eh, eo, et, eu);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic probe(input logic [27:0] a);
        addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset config, 4 MB installed, 16 MB limit, no TCM
        probe(28'h2400008);
        check(1, 1'b1, 25'h8, 1'b0, 1'b0);
        probe(28'h2FF0000);
        check(1, 1'b1, 25'h3F0000, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i].cfg);
            probe(VECS[i].addr);
            check(int'(VECS[i].req), VECS[i].hit, VECS[i].off, VECS[i].tcm, VECS[i].unc);
        end

        // R11: the write is not visible before its edge, and is visible after it
        write_cfg(32'h9);
        probe(28'hD000000);
        check(11, 1'b1, 25'h0, 1'b0, 1'b1);
        cfg_we    = 1'b1;
        cfg_wdata = 32'hE;
        #1;
        check(11, 1'b1, 25'h0, 1'b0, 1'b1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(11, 1'b1, 25'h1000000, 1'b0, 1'b1);

        // R1: reset restores defaults after a TCM configuration
        write_cfg(32'h2FF0019);
        probe(28'h2FF0000);
        check(8, 1'b0, 25'h0, 1'b1, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1, 1'b1, 25'h3F0000, 1'b0, 1'b0);
        probe(28'hD400010);
        check(1, 1'b1, 25'h10, 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule